// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a 32-bit integer execution datapath with a registered condition-flag store. One operation is presented per clock as a 4-bit opcode with up to three source operands, an immediate, a select that replaces the second register operand with that immediate, and a set-flags control. The 32-bit result is produced combinationally in the same cycle. The four flags (negative, zero, carry, overflow) are captured on the clock edge and hold their value until a later flag-setting operation changes them.

The supported operations are:

- arithmetic: add, subtract, multiply, and a multiply-subtract that removes the product of the second and third operands from the first;
- divide: unsigned and signed, each returning only the quotient;
- bitwise: AND, OR, XOR, and bit-clear;
- shifts: left shift, logical right shift, and rotate right.

Decode, the register file and pipelining belong to the surrounding core. The block only computes and keeps the flags. Divide completes in one cycle.

Top module: `int_alu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four flags are cleared to 0 at that edge.
- R2: When `use_imm` is 1, `imm` replaces `src_b` as the second operand of every two-operand operation. When `use_imm` is 0, `src_b` is used.
- R3: Add (opcode 0) and subtract (opcode 1) return the 32-bit sum or difference. When flags are set: N is result bit 31, and Z is 1 when the result is 0. C is the carry out for add; for subtract it is 1 when no borrow occurs. V is signed overflow.
- R4: The flags change only at a clock edge where `op_valid` and `set_flags` are both 1. At every other edge they hold.
- R5: Multiply (opcode 2) returns the low 32 bits of operand1 × operand2. Multiply-subtract (opcode 3) returns the low 32 bits of `src_a` − operand2 × `src_c`.
- R6: Unsigned divide (opcode 4) returns the truncated quotient. A divisor of 0 returns 0.
- R7: Signed divide (opcode 5) returns a two's-complement quotient rounded toward zero. A divisor of 0 returns 0, and 0x80000000 divided by 0xFFFFFFFF returns 0x80000000.
- R8: AND (opcode 6), OR (opcode 7), XOR (opcode 8) and bit-clear (opcode 9, `src_a` AND NOT operand2) act bitwise.
- R9: Left shift (opcode 10) and logical right shift (opcode 11) fill with zeros. Rotate right (opcode 12) moves the bits that leave at bit 0 into bit 31. For all three, the amount is operand2 bits [4:0].
- R10: A flag-setting update with opcodes 2 through 12 sets N and Z from the result and leaves C and V unchanged.
- R11: Opcodes 13 to 15 return a result of 0 and never change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| src_c | input | 32 | Third register operand (multiply-subtract) |
| imm | input | 32 | Immediate operand |
| use_imm | input | 1 | Use `imm` in place of `src_b` |
| set_flags | input | 1 | Update the flags with this operation |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets the sign and carry boundaries of add and subtract:

- all-ones plus one, and the largest positive value plus one, which catch a design that drops the carry or computes overflow from the wrong bits;
- a subtract that borrows, which catches an inverted no-borrow carry.

It divides by zero and divides the most negative value by −1. A divider without guards would return all ones or a wrong sign on these.

It follows a run of logical, multiply and divide operations that set flags. A design that clears C and V on these would lose the earlier carry and overflow.

It also checks the cases where the flags must hold:

- non-flag-setting operations;
- operations with `op_valid` low;
- undefined opcodes;
- shift amounts of 0 and of values above 31.

A flag register that updates too freely, or a shifter that uses more than five amount bits, shows up in these.

// File: rtl/alu_pkg.sv
// Package: shared opcode encoding and flag bundle for the integer ALU.
// Assumes a 4-bit opcode; codes above OP_ROR are undefined.
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_MLS  = 4'd3,
        OP_UDIV = 4'd4,
        OP_SDIV = 4'd5,
        OP_AND  = 4'd6,
        OP_ORR  = 4'd7,
        OP_EOR  = 4'd8,
        OP_BIC  = 4'd9,
        OP_LSL  = 4'd10,
        OP_LSR  = 4'd11,
        OP_ROR  = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu_arith_unit.sv
// Module: add, subtract, multiply and multiply-subtract.
// Assumes operands are already selected; carry and overflow are
// meaningful only for add and subtract and are 0 otherwise.
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    input  logic [WIDTH-1:0]   opc,
    output logic [WIDTH-1:0]   res,
    output logic               carry,
    output logic               ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   add_w;
    logic [WIDTH:0]   sub_w;
    logic [WIDTH-1:0] prod_lo;
    logic [WIDTH-1:0] mls_lo;

    // Purpose: wide sum and difference; the extra bit is the carry out.
    always_comb begin
        add_w = {1'b0, opa} + {1'b0, opb};
        sub_w = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, 1'b1};
    end

    // Purpose: truncated product and multiply-subtract.
    always_comb begin
        prod_lo = opa * opb;
        mls_lo  = opa - (opb * opc);
    end

    // Purpose: select the arithmetic result and its carry/overflow.
    always_comb begin
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        case (op)
            OP_ADD: begin
                res   = add_w[MSB:0];
                carry = add_w[WIDTH];
                ovf   = (opa[MSB] == opb[MSB]) && (add_w[MSB] != opa[MSB]);
            end
            OP_SUB: begin
                res   = sub_w[MSB:0];
                carry = sub_w[WIDTH];
                ovf   = (opa[MSB] != opb[MSB]) && (sub_w[MSB] != opa[MSB]);
            end
            OP_MUL:  res = prod_lo;
            OP_MLS:  res = mls_lo;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_div_unit.sv
// Module: single-cycle unsigned and signed quotient.
// Assumes a zero divisor yields a zero quotient. Signed divide works on
// magnitudes, so the most negative value over -1 wraps back to itself.
module alu_div_unit #(
    parameter int WIDTH = 32
) (
    input  logic               signed_mode,
    input  logic [WIDTH-1:0]   dividend,
    input  logic [WIDTH-1:0]   divisor,
    output logic [WIDTH-1:0]   quotient
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] mag_n;
    logic [WIDTH-1:0] mag_d;
    logic [WIDTH-1:0] mag_q;
    logic             neg_q;
    logic             div_zero;

    // Purpose: operand magnitudes and quotient sign for the chosen mode.
    always_comb begin
        div_zero = (divisor == '0);
        if (signed_mode) begin
            mag_n = dividend[MSB] ? (~dividend + 1'b1) : dividend;
            mag_d = divisor[MSB]  ? (~divisor + 1'b1)  : divisor;
            neg_q = dividend[MSB] ^ divisor[MSB];
        end else begin
            mag_n = dividend;
            mag_d = divisor;
            neg_q = 1'b0;
        end
    end

    // Purpose: unsigned magnitude quotient, guarded against zero divisor.
    always_comb begin
        mag_q = div_zero ? '0 : (mag_n / mag_d);
    end

    // Purpose: restore the sign of the quotient.
    always_comb begin
        quotient = neg_q ? (~mag_q + 1'b1) : mag_q;
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise operations and shifts/rotate.
// Assumes the shift amount is the low log2(WIDTH) bits of operand 2.
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    output logic [WIDTH-1:0]   res
);

    localparam int SHW = $clog2(WIDTH);

    logic [SHW-1:0]   amt;
    logic [WIDTH-1:0] shl_v;
    logic [WIDTH-1:0] shr_v;
    logic [WIDTH-1:0] rot_v;

    // Purpose: extract the shift amount.
    always_comb begin
        amt = opb[SHW-1:0];
    end

    // Purpose: logical shifts, zero filled.
    always_comb begin
        shl_v = opa << amt;
        shr_v = opa >> amt;
    end

    // Purpose: rotate right as one mux per output bit.
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_rot
            logic [SHW-1:0] src_idx;
            always_comb begin
                src_idx    = SHW'(gi) + amt;
                rot_v[gi]  = opa[src_idx];
            end
        end
    endgenerate

    // Purpose: select the logical result.
    always_comb begin
        case (op)
            OP_AND:  res = opa & opb;
            OP_ORR:  res = opa | opb;
            OP_EOR:  res = opa ^ opb;
            OP_BIC:  res = opa & ~opb;
            OP_LSL:  res = shl_v;
            OP_LSR:  res = shr_v;
            OP_ROR:  res = rot_v;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Module: persistent condition-flag store.
// Assumes the update enables are already qualified with valid and set-flags.
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_nz,
    input  logic       upd_cv,
    input  alu_flags_t nxt,
    output alu_flags_t cur
);

    // Purpose: clear on reset, otherwise load the enabled flag groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else begin
            if (upd_nz) begin
                cur.n <= nxt.n;
                cur.z <= nxt.z;
            end
            if (upd_cv) begin
                cur.c <= nxt.c;
                cur.v <= nxt.v;
            end
        end
    end

endmodule

// File: rtl/int_alu_core.sv
// Module: top of the integer ALU. Picks operand 2, routes the opcode to one
// of three datapath units, muxes the result and qualifies flag updates.
// Assumes a single operation per cycle; the result is combinational.
module int_alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [WIDTH-1:0]  src_a,
    input  logic [WIDTH-1:0]  src_b,
    input  logic [WIDTH-1:0]  src_c,
    input  logic [WIDTH-1:0]  imm,
    input  logic              use_imm,
    input  logic              set_flags,
    output logic [WIDTH-1:0]  result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_DIV,
        CLS_LOGIC,
        CLS_NONE
    } op_class_e;

    alu_op_e          op_e;
    op_class_e        op_cls;
    logic [WIDTH-1:0] opnd2;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] div_res;
    logic [WIDTH-1:0] logic_res;
    logic             arith_c;
    logic             arith_v;
    logic             upd_nz;
    logic             upd_cv;
    alu_flags_t       flg_nxt;
    alu_flags_t       flg_cur;

    // Purpose: decode the opcode into a unit class.
    always_comb begin
        op_e = alu_op_e'(op_code);
        case (op_e)
            OP_ADD, OP_SUB, OP_MUL, OP_MLS:        op_cls = CLS_ARITH;
            OP_UDIV, OP_SDIV:                      op_cls = CLS_DIV;
            OP_AND, OP_ORR, OP_EOR, OP_BIC,
            OP_LSL, OP_LSR, OP_ROR:                op_cls = CLS_LOGIC;
            default:                               op_cls = CLS_NONE;
        endcase
    end

    // Purpose: second operand select.
    always_comb begin
        opnd2 = use_imm ? imm : src_b;
    end

    alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .op    (op_e),
        .opa   (src_a),
        .opb   (opnd2),
        .opc   (src_c),
        .res   (arith_res),
        .carry (arith_c),
        .ovf   (arith_v)
    );

    alu_div_unit #(.WIDTH(WIDTH)) u_div (
        .signed_mode (op_e == OP_SDIV),
        .dividend    (src_a),
        .divisor     (opnd2),
        .quotient    (div_res)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .op  (op_e),
        .opa (src_a),
        .opb (opnd2),
        .res (logic_res)
    );

    // Purpose: result mux by class.
    always_comb begin
        case (op_cls)
            CLS_ARITH: result = arith_res;
            CLS_DIV:   result = div_res;
            CLS_LOGIC: result = logic_res;
            default:   result = '0;
        endcase
    end

    // Purpose: next flag values and the qualified update enables.
    always_comb begin
        flg_nxt.n = result[WIDTH-1];
        flg_nxt.z = (result == '0);
        flg_nxt.c = arith_c;
        flg_nxt.v = arith_v;
        upd_nz    = op_valid && set_flags && (op_cls != CLS_NONE);
        upd_cv    = upd_nz && ((op_e == OP_ADD) || (op_e == OP_SUB));
    end

    alu_flag_reg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_nz (upd_nz),
        .upd_cv (upd_cv),
        .nxt    (flg_nxt),
        .cur    (flg_cur)
    );

    // Purpose: drive the flag ports.
    always_comb begin
        flag_n = flg_cur.n;
        flag_z = flg_cur.z;
        flag_c = flg_cur.c;
        flag_v = flg_cur.v;
    end

endmodule

// File: rtl/int_alu_core_chk.sv
// Module: property checker for int_alu_core, attached with bind.
// Assumes it observes the top-level ports only.
module int_alu_core_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [WIDTH-1:0]  src_b,
    input logic [WIDTH-1:0]  imm,
    input logic              use_imm,
    input logic              set_flags,
    input logic [WIDTH-1:0]  result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);

    logic upd_any;
    logic is_div;
    logic [WIDTH-1:0] div_by;

    // Purpose: helper terms observed at the ports.
    always_comb begin
        upd_any = op_valid && set_flags && (op_code <= OP_ROR);
        is_div  = (op_code == OP_UDIV) || (op_code == OP_SDIV);
        div_by  = use_imm ? imm : src_b;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000)); // R1

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_any |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R4

    AST_Z_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_any |=> (flag_z == ($past(result) == '0))); // R10

    AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_any |=> (flag_n == $past(result[WIDTH-1]))); // R10

    AST_CV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_any && (op_code >= OP_MUL)) |=> $stable({flag_c, flag_v})); // R10

    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_div && (div_by == '0)) |-> (result == '0)); // R6

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > OP_ROR) |-> (result == '0)); // R11

endmodule

bind int_alu_core int_alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .src_b     (src_b),
    .imm       (imm),
    .use_imm   (use_imm),
    .set_flags (set_flags),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
);

// File: tb/int_alu_core_test.sv
`timescale 1ns/1ps
module int_alu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] src_a = '0, src_b = '0, src_c = '0, imm = '0;
    logic        use_imm = 1'b0, set_flags = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  flg;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic [3:0] mdl_flg = 4'b0000;   // {N,Z,C,V}

    always #2.5 clk = ~clk;

    int_alu_core uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
        .use_imm(use_imm), .set_flags(set_flags), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: apply one operation and push the expected outcome.
    task automatic drive(input logic vld, input logic [3:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] im,
                         input logic ui, input logic s,
                         input logic [31:0] exp_res, input string tag);
        logic [31:0] o2;
        logic [32:0] w;
        item_t it;
        @(negedge clk);
        op_valid = vld; op_code = op; src_a = a; src_b = b; src_c = c;
        imm = im; use_imm = ui; set_flags = s;
        o2 = ui ? im : b;
        if (vld && s && op <= 4'd12) begin
            mdl_flg[3] = exp_res[31];
            mdl_flg[2] = (exp_res == 32'd0);
            if (op == 4'd0) begin
                w = {1'b0, a} + {1'b0, o2};
                mdl_flg[1] = w[32];
                mdl_flg[0] = (a[31] == o2[31]) && (w[31] != a[31]);
            end else if (op == 4'd1) begin
                mdl_flg[1] = (a >= o2);
                w = {1'b0, a - o2};
                mdl_flg[0] = (a[31] != o2[31]) && (w[31] != a[31]);
            end
        end
        it.res = exp_res; it.flg = mdl_flg; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after each edge, inputs still held.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (result !== it.res || {flag_n, flag_z, flag_c, flag_v} !== it.flg) begin
                    fails++;
                    $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                             it.tag, result, {flag_n, flag_z, flag_c, flag_v}, it.res, it.flg);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({flag_n, flag_z, flag_c, flag_v} !== 4'b0000) begin
            fails++;
            $display("FAIL R1: flags=%b expected 0000", {flag_n, flag_z, flag_c, flag_v});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R2 add and subtract boundaries
        drive(1, 0, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 1, 32'h0,        "R3 add carry to zero");
        drive(1, 0, 32'h7FFFFFFF, 32'h5, 0, 1, 1, 1, 32'h80000000, "R2 R3 add imm overflow");
        drive(1, 0, 32'h1, 32'h2, 0, 0, 0, 0, 32'h3,               "R4 add no set flags");
        drive(1, 1, 32'd10, 32'd99, 0, 32'd10, 1, 1, 32'h0,        "R2 R3 sub imm equal");
        drive(1, 1, 32'd5, 32'd10, 0, 0, 0, 1, 32'hFFFFFFFB,       "R3 sub borrow");
        drive(1, 1, 32'h80000000, 32'h1, 0, 0, 0, 1, 32'h7FFFFFFF, "R3 sub overflow");
        // R8/R10 bitwise
        drive(1, 6, 32'hFFFFFF0F, 0, 0, 32'd100, 1, 1, 32'h4,      "R8 R10 and imm keeps CV");
        drive(1, 7, 32'hF0, 32'h0F, 0, 0, 0, 0, 32'hFF,            "R8 or");
        drive(1, 8, 32'hAAAAAAAA, 32'hAAAAAAAA, 0, 0, 0, 1, 32'h0, "R8 R10 xor zero");
        drive(1, 9, 32'hFFFF00FF, 32'hF0, 0, 0, 0, 1, 32'hFFFF000F, "R8 R10 bit clear");
        // R9 shifts
        drive(1, 10, 32'h40000001, 0, 0, 32'd2, 1, 0, 32'h4,       "R9 lsl 2");
        drive(1, 11, 32'h80000001, 0, 0, 32'd2, 1, 0, 32'h20000000, "R9 lsr 2");
        drive(1, 12, 32'h3, 0, 0, 32'd2, 1, 0, 32'hC0000000,       "R9 ror 2");
        drive(1, 10, 32'h1, 32'd34, 0, 0, 0, 0, 32'h4,             "R9 lsl amount low bits");
        drive(1, 12, 32'h12345678, 32'd0, 0, 0, 0, 0, 32'h12345678, "R9 ror zero");
        // R5 multiply
        drive(1, 2, 32'h10000, 32'h10000, 0, 0, 0, 1, 32'h0,       "R5 R10 mul truncates");
        drive(1, 2, 32'hFFFFFFFF, 32'd3, 0, 0, 0, 0, 32'hFFFFFFFD, "R5 mul negative");
        drive(1, 3, 32'd100, 32'd3, 32'd7, 0, 0, 0, 32'd79,        "R5 mls");
        drive(1, 3, 32'd0, 32'd1, 32'd1, 0, 0, 0, 32'hFFFFFFFF,    "R5 mls wrap");
        // R6 unsigned divide
        drive(1, 4, 32'd100, 32'd7, 0, 0, 0, 0, 32'd14,            "R6 udiv");
        drive(1, 4, 32'hFFFFFFFF, 32'd2, 0, 0, 0, 0, 32'h7FFFFFFF, "R6 udiv large");
        drive(1, 4, 32'd5, 32'd0, 0, 0, 0, 1, 32'h0,               "R6 udiv by zero");
        // R7 signed divide
        drive(1, 5, 32'hFFFFFF9C, 32'd7, 0, 0, 0, 0, 32'hFFFFFFF2, "R7 sdiv neg/pos");
        drive(1, 5, 32'd100, 32'hFFFFFFF9, 0, 0, 0, 0, 32'hFFFFFFF2, "R7 sdiv pos/neg");
        drive(1, 5, 32'hFFFFFF9C, 32'hFFFFFFF9, 0, 0, 0, 0, 32'd14, "R7 sdiv neg/neg");
        drive(1, 5, 32'h80000000, 32'hFFFFFFFF, 0, 0, 0, 1, 32'h80000000, "R7 sdiv min by -1");
        drive(1, 5, 32'd7, 32'hFFFF, 0, 32'd0, 1, 0, 32'h0,        "R7 sdiv by zero imm");
        // R4/R11 no-update cases
        drive(0, 0, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 1, 32'h0,        "R4 op_valid low holds flags");
        drive(1, 13, 32'h5, 32'h5, 0, 0, 0, 1, 32'h0,              "R11 undefined opcode 13");
        drive(1, 15, 32'h0, 32'h0, 0, 0, 0, 1, 32'h0,              "R11 undefined opcode 15");
        drive(1, 1, 32'd3, 32'd3, 0, 0, 0, 1, 32'h0,               "R3 sub equal sets Z");

        @(negedge clk);
        op_valid = 1'b0; set_flags = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end

endmodule